// File: doc/BRIEF.md
# I2C Transaction Sequencer

This block drives a status-reporting I2C byte engine through whole device transactions with no processor in the loop. A command names a 7-bit device, a kind (write, combined read, or presence probe), an offset of up to four bytes and a payload length. The sequencer issues one engine step at a time: START, SEND, RECV or STOP. After each step it waits for the engine's completion flag and compares the returned status code with the single code that the step must produce.

Write payload bytes are pulled from a stream, one pop per data byte sent. Read bytes are pushed out with a one-cycle valid strobe. When a status code differs from the expected one, or a step never completes, the transaction is cut short. A STOP is still issued, and the block then waits for the engine to report an idle bus. Completion is signalled by a one-cycle done pulse. A 32-bit diagnostic word goes with it and stays put until the next completion.

Top module: `i2c_txn_seq`

## Requirements
- R1: A command is taken only in a cycle where cmd_ready_o is high. The START request follows in the next cycle. cmd_valid_i has no effect while a transaction runs.
- R2: Engine step codes on eng_op_o are 0 START, 1 SEND, 2 RECV and 3 STOP. A write (kind 0) runs this sequence:
  - START, expecting 0x08.
  - SEND of {dev,0}, expecting 0x18.
  - One SEND per offset byte, then one per payload byte, each expecting 0x28. Each payload SEND pulses wr_pop_o and carries wr_data_i.
  - STOP.
- R3: Offset bytes come from cmd_off_i least significant byte first. Their number is cmd_off_len_i, with any value above 4 treated as 4.
- R4: A read (kind 1) with a nonzero offset count runs these steps:
  - The write addressing and the offset bytes.
  - A second START with no STOP before it, expecting 0x10.
  - SEND of {dev,1}, expecting 0x40.
- R5: A read with zero offset bytes starts with a plain START expecting 0x08, followed at once by SEND of {dev,1}.
- R6: A read issues one RECV per payload byte. Every byte but the last is acknowledged (eng_ack_o=1, expects 0x50). The last is not (eng_ack_o=0, expects 0x58). A received byte appears on rd_data_o with rd_valid_o only when its status matched.
- R7: A probe (kind 2 or 3) runs START (0x08), SEND of {dev,1} (0x40), one non-acknowledged RECV (0x58) and STOP. It outputs no data and reports success only if every step matched.
- R8: A status mismatch ends the transaction with a STOP. The error word is:
  - bits 31:24 = 1;
  - bits 23:16 = the step's control byte with the flag bit 0x08 set;
  - bits 15:8 = the received status;
  - bits 7:0 = the expected status.
- R9: A step whose flag has not risen within TIMEOUT_TICKS tick periods (TICK_CYCLES clocks each) ends with a STOP. It yields class 2, the step's control byte, the status present at expiry, and the expected code.
- R10: Every transaction ends with a STOP and a wait for status 0xF8, bounded by the same limit. A STOP timeout reports {2, 0x50, status, 0xF8} only when no earlier step failed. Otherwise the first failure's word is kept.
- R11: done_o is high for exactly one clock, with cmd_ready_o high. err_o changes only together with done_o and is zero after a successful transaction.
- R12: Control bytes are:
  - 0x60 for START;
  - 0x40 for SEND;
  - 0x44 for an acknowledged RECV;
  - 0x40 for a non-acknowledged RECV;
  - 0x50 for STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Idle, command can be taken |
| cmd_kind_i | input | 2 | 0 write, 1 read, 2/3 probe |
| cmd_dev_i | input | 7 | Device address |
| cmd_off_i | input | 32 | Offset value |
| cmd_off_len_i | input | 3 | Offset byte count (0 to 4) |
| cmd_len_i | input | LEN_W | Payload byte count |
| wr_data_i | input | 8 | Next payload byte to write |
| wr_pop_o | output | 1 | Payload byte consumed |
| rd_valid_o | output | 1 | Received byte strobe |
| rd_data_o | output | 8 | Received byte |
| done_o | output | 1 | Transaction finished pulse |
| err_o | output | 32 | Diagnostic word, zero on success |
| eng_req_o | output | 1 | Engine step request pulse |
| eng_op_o | output | 2 | Engine step code |
| eng_byte_o | output | 8 | Byte for a SEND step |
| eng_ack_o | output | 1 | Acknowledge the received byte |
| eng_flag_i | input | 1 | Engine step complete flag, low from the cycle after a request |
| eng_status_i | input | 8 | Engine status code |
| eng_rdata_i | input | 8 | Engine received byte |

## Verification
The bench targets the places where the step plan forks:
- The second START of a combined read. A design that put a STOP there, or expected 0x08, would show an extra step or report a false error.
- The acknowledge of the final read byte. Getting it wrong yields 0x50 against 0x58.
- The offset byte order and the clamp above four, which show up as wrong or extra SEND bytes in the step log.

It injects a bad status on a middle byte, a hung START and a hung STOP. This confirms that the remaining bytes are not issued, that a mismatched read byte is withheld, that a STOP follows every failure, and that the first failure's word is not overwritten by a later STOP timeout.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [1:0] {OP_START = 2'd0, OP_SEND = 2'd1, OP_RECV = 2'd2, OP_STOP = 2'd3} eng_op_e;
  typedef enum logic [2:0] {PH_START, PH_ADDR, PH_OFF, PH_WDATA, PH_RDATA} phase_e;
  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_STOP_ISSUE, S_STOP_WAIT} seq_st_e;

  localparam logic [1:0] KIND_WRITE = 2'd0;
  localparam logic [1:0] KIND_READ  = 2'd1;

  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RESTART = 8'h10;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_DW_ACK  = 8'h28;
  localparam logic [7:0] ST_AR_ACK  = 8'h40;
  localparam logic [7:0] ST_DR_ACK  = 8'h50;
  localparam logic [7:0] ST_DR_NAK  = 8'h58;
  localparam logic [7:0] ST_IDLE    = 8'hF8;

  localparam logic [7:0] C_EN    = 8'h40;
  localparam logic [7:0] C_START = 8'h20;
  localparam logic [7:0] C_STOP  = 8'h10;
  localparam logic [7:0] C_FLAG  = 8'h08;
  localparam logic [7:0] C_ACK   = 8'h04;

  localparam logic [7:0] ERR_STATUS  = 8'h01;
  localparam logic [7:0] ERR_TIMEOUT = 8'h02;

  function automatic logic [31:0] pack_err(input logic [7:0] cls, input logic [7:0] ctrl,
                                           input logic [7:0] st, input logic [7:0] exp_st);
    return {cls, ctrl, st, exp_st};
  endfunction
endpackage

// File: rtl/i2c_seq_timer.sv
module i2c_seq_timer #(
  parameter int TICK_CYCLES   = 4,
  parameter int TIMEOUT_TICKS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic expired_o
);
  localparam int PRE_W = $clog2(TICK_CYCLES + 1);
  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;

  assign expired_o = (cnt_q == CNT_W'(TIMEOUT_TICKS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!expired_o) begin
      if (pre_q == PRE_W'(TICK_CYCLES - 1)) begin
        pre_q <= '0;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_seq_step.sv
module i2c_seq_step
  import i2c_seq_pkg::*;
(
  input  phase_e       phase_i,
  input  logic         rd_i,
  input  logic         restart_i,
  input  logic         last_i,
  input  logic [6:0]   dev_i,
  input  logic [7:0]   off_byte_i,
  input  logic [7:0]   wr_byte_i,
  output eng_op_e      op_o,
  output logic [7:0]   byte_o,
  output logic         ack_o,
  output logic [7:0]   ctrl_o,
  output logic [7:0]   exp_o
);
  always_comb begin
    op_o   = OP_SEND;
    byte_o = 8'h00;
    ack_o  = 1'b0;
    ctrl_o = C_EN;
    exp_o  = ST_DW_ACK;
    unique case (phase_i)
      PH_START: begin
        op_o   = OP_START;
        ctrl_o = C_EN | C_START;
        exp_o  = restart_i ? ST_RESTART : ST_START;
      end
      PH_ADDR: begin
        byte_o = {dev_i, rd_i};
        exp_o  = rd_i ? ST_AR_ACK : ST_AW_ACK;
      end
      PH_OFF:   byte_o = off_byte_i;
      PH_WDATA: byte_o = wr_byte_i;
      PH_RDATA: begin
        op_o   = OP_RECV;
        ack_o  = !last_i;
        ctrl_o = last_i ? C_EN : (C_EN | C_ACK);
        exp_o  = last_i ? ST_DR_NAK : ST_DR_ACK;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/i2c_seq_next.sv
module i2c_seq_next
  import i2c_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  phase_e           phase_i,
  input  logic             rd_i,
  input  logic             rs_i,
  input  logic [LEN_W-1:0] idx_i,
  input  logic [2:0]       offn_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             is_read_i,
  output phase_e           phase_o,
  output logic             rd_o,
  output logic             rs_o,
  output logic [LEN_W-1:0] idx_o,
  output logic             stop_o
);
  logic post_off;

  always_comb begin
    phase_o  = phase_i;
    rd_o     = rd_i;
    rs_o     = rs_i;
    idx_o    = idx_i;
    stop_o   = 1'b0;
    post_off = 1'b0;
    unique case (phase_i)
      PH_START: phase_o = PH_ADDR;
      PH_ADDR: begin
        if (rd_i) begin
          if (len_i != '0) begin
            phase_o = PH_RDATA;
            idx_o   = '0;
          end else begin
            stop_o = 1'b1;
          end
        end else if (offn_i != 3'd0) begin
          phase_o = PH_OFF;
          idx_o   = '0;
        end else begin
          post_off = 1'b1;
        end
      end
      PH_OFF: begin
        if (idx_i == LEN_W'(offn_i) - LEN_W'(1)) post_off = 1'b1;
        else idx_o = idx_i + 1'b1;
      end
      PH_WDATA, PH_RDATA: begin
        if (idx_i == len_i - LEN_W'(1)) stop_o = 1'b1;
        else idx_o = idx_i + 1'b1;
      end
      default: stop_o = 1'b1;
    endcase
    // end of write-addressing phase: turn around for a read or go to payload
    if (post_off) begin
      if (is_read_i) begin
        phase_o = PH_START;
        rd_o    = 1'b1;
        rs_o    = 1'b1;
      end else if (len_i != '0) begin
        phase_o = PH_WDATA;
        idx_o   = '0;
      end else begin
        stop_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
  import i2c_seq_pkg::*;
#(
  parameter int LEN_W         = 8,
  parameter int TICK_CYCLES   = 4,
  parameter int TIMEOUT_TICKS = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [1:0]       cmd_kind_i,
  input  logic [6:0]       cmd_dev_i,
  input  logic [31:0]      cmd_off_i,
  input  logic [2:0]       cmd_off_len_i,
  input  logic [LEN_W-1:0] cmd_len_i,
  input  logic [7:0]       wr_data_i,
  output logic             wr_pop_o,
  output logic             rd_valid_o,
  output logic [7:0]       rd_data_o,
  output logic             done_o,
  output logic [31:0]      err_o,
  output logic             eng_req_o,
  output logic [1:0]       eng_op_o,
  output logic [7:0]       eng_byte_o,
  output logic             eng_ack_o,
  input  logic             eng_flag_i,
  input  logic [7:0]       eng_status_i,
  input  logic [7:0]       eng_rdata_i
);
  localparam int MAX_OFF = 4;

  seq_st_e          st_q;
  phase_e           phase_q, nx_phase;
  logic [1:0]       kind_q;
  logic [6:0]       dev_q;
  logic [31:0]      off_q;
  logic [2:0]       offn_q;
  logic [LEN_W-1:0] len_q, idx_q, nx_idx, len_eff;
  logic             rd_q, rs_q, nx_rd, nx_rs, nx_stop;
  logic             failed_q;
  logic [31:0]      err_acc_q;
  logic [7:0]       ctrl_q, exp_q;

  eng_op_e    step_op;
  logic [7:0] step_byte, step_ctrl, step_exp, off_byte;
  logic       step_ack, last, is_probe, expired;

  assign is_probe = kind_q[1];
  assign len_eff  = is_probe ? LEN_W'(1) : len_q;
  assign last     = (idx_q == len_eff - LEN_W'(1));
  assign off_byte = off_q[8*idx_q[1:0] +: 8];

  i2c_seq_step u_step (
    .phase_i(phase_q), .rd_i(rd_q), .restart_i(rs_q), .last_i(last),
    .dev_i(dev_q), .off_byte_i(off_byte), .wr_byte_i(wr_data_i),
    .op_o(step_op), .byte_o(step_byte), .ack_o(step_ack),
    .ctrl_o(step_ctrl), .exp_o(step_exp)
  );

  i2c_seq_next #(.LEN_W(LEN_W)) u_next (
    .phase_i(phase_q), .rd_i(rd_q), .rs_i(rs_q), .idx_i(idx_q),
    .offn_i(offn_q), .len_i(len_eff), .is_read_i(kind_q == KIND_READ),
    .phase_o(nx_phase), .rd_o(nx_rd), .rs_o(nx_rs), .idx_o(nx_idx), .stop_o(nx_stop)
  );

  i2c_seq_timer #(.TICK_CYCLES(TICK_CYCLES), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(eng_req_o), .expired_o(expired)
  );

  assign cmd_ready_o = (st_q == S_IDLE);
  assign eng_req_o   = (st_q == S_ISSUE) || (st_q == S_STOP_ISSUE);
  assign eng_op_o    = (st_q == S_STOP_ISSUE) ? OP_STOP : step_op;
  assign eng_byte_o  = (st_q == S_ISSUE) ? step_byte : 8'h00;
  assign eng_ack_o   = (st_q == S_ISSUE) && step_ack;
  assign wr_pop_o    = (st_q == S_ISSUE) && (phase_q == PH_WDATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      phase_q   <= PH_START;
      kind_q    <= '0;
      dev_q     <= '0;
      off_q     <= '0;
      offn_q    <= '0;
      len_q     <= '0;
      idx_q     <= '0;
      rd_q      <= 1'b0;
      rs_q      <= 1'b0;
      failed_q  <= 1'b0;
      err_acc_q <= '0;
      ctrl_q    <= '0;
      exp_q     <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o <= '0;
      done_o    <= 1'b0;
      err_o     <= '0;
    end else begin
      done_o     <= 1'b0;
      rd_valid_o <= 1'b0;
      unique case (st_q)
        S_IDLE: if (cmd_valid_i) begin
          kind_q    <= cmd_kind_i;
          dev_q     <= cmd_dev_i;
          off_q     <= cmd_off_i;
          offn_q    <= (cmd_off_len_i > 3'(MAX_OFF)) ? 3'(MAX_OFF) : cmd_off_len_i;
          len_q     <= cmd_len_i;
          phase_q   <= PH_START;
          idx_q     <= '0;
          rs_q      <= 1'b0;
          rd_q      <= (cmd_kind_i != KIND_WRITE) && (cmd_kind_i[1] || cmd_off_len_i == 3'd0);
          failed_q  <= 1'b0;
          err_acc_q <= '0;
          st_q      <= S_ISSUE;
        end
        S_ISSUE: begin
          ctrl_q <= step_ctrl;
          exp_q  <= step_exp;
          st_q   <= S_WAIT;
        end
        S_WAIT: begin
          if (eng_flag_i) begin
            if (eng_status_i == exp_q) begin
              if (phase_q == PH_RDATA && !is_probe) begin
                rd_valid_o <= 1'b1;
                rd_data_o  <= eng_rdata_i;
              end
              phase_q <= nx_phase;
              rd_q    <= nx_rd;
              rs_q    <= nx_rs;
              idx_q   <= nx_idx;
              st_q    <= nx_stop ? S_STOP_ISSUE : S_ISSUE;
            end else begin
              failed_q  <= 1'b1;
              err_acc_q <= pack_err(ERR_STATUS, ctrl_q | C_FLAG, eng_status_i, exp_q);
              st_q      <= S_STOP_ISSUE;
            end
          end else if (expired) begin
            failed_q  <= 1'b1;
            err_acc_q <= pack_err(ERR_TIMEOUT, ctrl_q, eng_status_i, exp_q);
            st_q      <= S_STOP_ISSUE;
          end
        end
        S_STOP_ISSUE: st_q <= S_STOP_WAIT;
        S_STOP_WAIT: begin
          if (eng_status_i == ST_IDLE) begin
            err_o  <= err_acc_q;
            done_o <= 1'b1;
            st_q   <= S_IDLE;
          end else if (expired) begin
            err_o  <= failed_q ? err_acc_q
                               : pack_err(ERR_TIMEOUT, C_EN | C_STOP, eng_status_i, ST_IDLE);
            done_o <= 1'b1;
            st_q   <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_seq_chk.sv
module i2c_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_i,
  input logic        cmd_ready_o,
  input logic        done_o,
  input logic [31:0] err_o,
  input logic        eng_req_o,
  input logic [1:0]  eng_op_o,
  input logic        wr_pop_o,
  input logic        rd_valid_o
);
  // R1
  accept_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ready_o && cmd_valid_i) |=> (!cmd_ready_o && eng_req_o && eng_op_o == 2'd0));
  // R1
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o |-> !cmd_ready_o);
  // R2
  req_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o |=> !eng_req_o);
  // R2
  pop_send_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pop_o |-> (eng_req_o && eng_op_o == 2'd1));
  // R6
  rdv_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !cmd_ready_o);
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cmd_ready_o);
  // R11
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(err_o));
endmodule

bind i2c_txn_seq i2c_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
  .done_o(done_o), .err_o(err_o), .eng_req_o(eng_req_o), .eng_op_o(eng_op_o),
  .wr_pop_o(wr_pop_o), .rd_valid_o(rd_valid_o)
);

// File: tb/tb_i2c_txn_seq.sv
module tb_i2c_txn_seq;
  localparam int LEN_W = 8;
  localparam int TICK  = 2;
  localparam int TMO   = 1000;
  localparam int LIMIT = TICK * TMO;
  localparam int DLY   = 3;
  localparam logic [6:0] SDEV = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_kind = '0;
  logic [6:0] cmd_dev = '0;
  logic [31:0] cmd_off = '0;
  logic [2:0] cmd_offn = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic [7:0] wr_data, rd_data, eng_byte;
  logic wr_pop, rd_valid, done, eng_req, eng_ack;
  logic [31:0] err;
  logic [1:0] eng_op;
  logic s_flag;
  logic [7:0] s_status, s_rdata;

  i2c_txn_seq #(.LEN_W(LEN_W), .TICK_CYCLES(TICK), .TIMEOUT_TICKS(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_kind_i(cmd_kind), .cmd_dev_i(cmd_dev), .cmd_off_i(cmd_off), .cmd_off_len_i(cmd_offn),
    .cmd_len_i(cmd_len), .wr_data_i(wr_data), .wr_pop_o(wr_pop), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data), .done_o(done), .err_o(err), .eng_req_o(eng_req), .eng_op_o(eng_op),
    .eng_byte_o(eng_byte), .eng_ack_o(eng_ack), .eng_flag_i(s_flag), .eng_status_i(s_status),
    .eng_rdata_i(s_rdata)
  );

  // stub configuration, driven only by the test tasks
  int inj_step = -1, hang_step = -1;
  logic [7:0] inj_code = 8'h00;
  logic stop_hang = 1'b0;
  logic [7:0] wbuf [0:63];

  // behavioural byte engine
  logic pend, cur_hang, cur_inj, cur_ack, in_txn, addr_next;
  logic [1:0] cur_op;
  logic [7:0] cur_byte, rcv_n;
  logic [3:0] dcnt;
  int req_n;
  logic [1:0] log_op [0:63];
  logic [7:0] log_byte [0:63];
  logic log_ack [0:63];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_flag <= 1'b0; s_status <= 8'hF8; s_rdata <= 8'h00; pend <= 1'b0;
      cur_hang <= 1'b0; cur_inj <= 1'b0; cur_ack <= 1'b0; cur_op <= 2'd0; cur_byte <= 8'h00;
      in_txn <= 1'b0; addr_next <= 1'b0; rcv_n <= 8'h00; dcnt <= 4'd0; req_n <= 0;
    end else begin
      if (cmd_valid && cmd_ready) begin req_n <= 0; rcv_n <= 8'h00; end
      if (eng_req) begin
        if (req_n < 64) begin
          log_op[req_n] <= eng_op; log_byte[req_n] <= eng_byte; log_ack[req_n] <= eng_ack;
        end
        req_n <= req_n + 1;
        s_flag <= 1'b0; pend <= 1'b1; dcnt <= 4'(DLY);
        cur_op <= eng_op; cur_byte <= eng_byte; cur_ack <= eng_ack;
        cur_hang <= (req_n == hang_step); cur_inj <= (req_n == inj_step);
        if (eng_op == 2'd3) in_txn <= 1'b0;
      end else if (pend) begin
        if (dcnt != 4'd0) dcnt <= dcnt - 4'd1;
        else if (!cur_hang) begin
          pend <= 1'b0;
          case (cur_op)
            2'd0: begin s_status <= in_txn ? 8'h10 : 8'h08; in_txn <= 1'b1; addr_next <= 1'b1; s_flag <= 1'b1; end
            2'd1: begin
              if (addr_next)
                s_status <= (cur_byte[7:1] == SDEV) ? (cur_byte[0] ? 8'h40 : 8'h18)
                                                     : (cur_byte[0] ? 8'h48 : 8'h20);
              else s_status <= 8'h28;
              addr_next <= 1'b0; s_flag <= 1'b1;
            end
            2'd2: begin
              s_rdata <= 8'hC0 + rcv_n; rcv_n <= rcv_n + 8'd1;
              s_status <= cur_ack ? 8'h50 : 8'h58; s_flag <= 1'b1;
            end
            default: if (!stop_hang) s_status <= 8'hF8;
          endcase
          if (cur_inj && cur_op != 2'd3) s_status <= inj_code;
        end
      end
    end
  end

  // output monitor
  int rd_n, pop_n, done_total;
  logic [7:0] rd_buf [0:63];
  assign wr_data = wbuf[pop_n[5:0]];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rd_n <= 0; pop_n <= 0; done_total <= 0; end
    else begin
      if (cmd_valid && cmd_ready) begin rd_n <= 0; pop_n <= 0; end
      else begin
        if (rd_valid && rd_n < 64) begin rd_buf[rd_n] <= rd_data; rd_n <= rd_n + 1; end
        if (wr_pop) pop_n <= pop_n + 1;
      end
      if (done) done_total <= done_total + 1;
    end
  end

  int checks = 0, errors = 0, cyc_total = 0;
  int exp_n;
  logic [1:0] exp_op [0:63];
  logic [7:0] exp_b [0:63];
  logic exp_ack [0:63];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [7:0] b, input logic a);
    exp_op[exp_n] = op; exp_b[exp_n] = b; exp_ack[exp_n] = a; exp_n++;
  endtask

  task automatic check_log(input string tag);
    check({tag, " step count"}, req_n, exp_n);
    for (int i = 0; i < exp_n && i < req_n; i++) begin
      check({tag, " op"}, {30'd0, log_op[i]}, {30'd0, exp_op[i]});
      if (exp_op[i] == 2'd1) check({tag, " byte"}, {24'd0, log_byte[i]}, {24'd0, exp_b[i]});
      if (exp_op[i] == 2'd2) check({tag, " ack"}, {31'd0, log_ack[i]}, {31'd0, exp_ack[i]});
    end
  endtask

  task automatic launch(input logic [1:0] k, input logic [6:0] d, input logic [31:0] o,
                        input logic [2:0] on, input logic [LEN_W-1:0] l);
    int w;
    w = 0;
    while (!cmd_ready && w < 5000) begin @(negedge clk); w++; end
    cmd_kind = k; cmd_dev = d; cmd_off = o; cmd_offn = on; cmd_len = l; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // waits for done, then checks pulse width and error word hold (R11)
  task automatic finish(input string tag, output int cyc, output logic [31:0] e);
    cyc = 1;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    check({tag, " R11 done seen"}, {31'd0, done}, 32'd1);
    e = err;
    @(negedge clk);
    check({tag, " R11 done one cycle"}, {31'd0, done}, 32'd0);
    repeat (5) @(negedge clk);
    check({tag, " R11 err held"}, err, e);
  endtask

  task automatic t_write_off2;
    int c; logic [31:0] e;
    wbuf[0] = 8'h10; wbuf[1] = 8'h20; wbuf[2] = 8'h30;
    exp_n = 0;
    push(0, 0, 0); push(1, 8'hA0, 0); push(1, 8'hC3, 0); push(1, 8'hB2, 0);
    push(1, 8'h10, 0); push(1, 8'h20, 0); push(1, 8'h30, 0); push(3, 0, 0);
    launch(2'd0, SDEV, 32'h11A1B2C3, 3'd2, 8'd3);
    finish("R2 write", c, e);
    check("R2 write err", e, 32'h0);
    check_log("R2/R3 write off2");
    check("R2 pops", pop_n, 3);
  endtask

  task automatic t_write_clamp;
    int c; logic [31:0] e;
    wbuf[0] = 8'h5A;
    exp_n = 0;
    push(0, 0, 0); push(1, 8'hA0, 0); push(1, 8'h11, 0); push(1, 8'h22, 0);
    push(1, 8'h33, 0); push(1, 8'h44, 0); push(1, 8'h5A, 0); push(3, 0, 0);
    launch(2'd0, SDEV, 32'h44332211, 3'd7, 8'd1);
    finish("R3 clamp", c, e);
    check("R3 clamp err", e, 32'h0);
    check_log("R3 offset clamp");
  endtask

  task automatic t_write_empty;
    int c; logic [31:0] e;
    exp_n = 0;
    push(0, 0, 0); push(1, 8'hA0, 0); push(3, 0, 0);
    launch(2'd0, SDEV, 32'h0, 3'd0, 8'd0);
    finish("R2 empty", c, e);
    check("R2 empty err", e, 32'h0);
    check_log("R2 empty write");
  endtask

  task automatic t_read_off;
    int c; logic [31:0] e;
    exp_n = 0;
    push(0, 0, 0); push(1, 8'hA0, 0); push(1, 8'h77, 0); push(0, 0, 0); push(1, 8'hA1, 0);
    push(2, 0, 1); push(2, 0, 1); push(2, 0, 0); push(3, 0, 0);
    launch(2'd1, SDEV, 32'h00000077, 3'd1, 8'd3);
    finish("R4 read", c, e);
    check("R4 read err", e, 32'h0);
    check_log("R4/R6 read off");
    check("R6 rd count", rd_n, 3);
    for (int i = 0; i < 3; i++) check("R6 rd data", {24'd0, rd_buf[i]}, 32'hC0 + i);
  endtask

  task automatic t_read_plain;
    int c; logic [31:0] e;
    exp_n = 0;
    push(0, 0, 0); push(1, 8'hA1, 0); push(2, 0, 1); push(2, 0, 0); push(3, 0, 0);
    launch(2'd1, SDEV, 32'hFFFFFFFF, 3'd0, 8'd2);
    finish("R5 read", c, e);
    check("R5 read err", e, 32'h0);
    check_log("R5 plain read");
    check("R5 rd count", rd_n, 2);
  endtask

  task automatic t_probe_ok;
    int c; logic [31:0] e;
    exp_n = 0;
    push(0, 0, 0); push(1, 8'hA1, 0); push(2, 0, 0); push(3, 0, 0);
    launch(2'd2, SDEV, 32'h0, 3'd3, 8'd5);
    finish("R7 probe", c, e);
    check("R7 probe err", e, 32'h0);
    check_log("R7 probe");
    check("R7 no data", rd_n, 0);
  endtask

  task automatic t_probe_miss;
    int c; logic [31:0] e;
    exp_n = 0;
    push(0, 0, 0); push(1, 8'h45, 0); push(3, 0, 0);
    launch(2'd2, 7'h22, 32'h0, 3'd0, 8'd1);
    finish("R7 miss", c, e);
    check("R7/R8/R12 miss err", e, 32'h01484840);
    check_log("R7/R10 miss");
  endtask

  task automatic t_inj_write;
    int c; logic [31:0] e;
    wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03;
    inj_step = 3; inj_code = 8'h30;
    exp_n = 0;
    push(0, 0, 0); push(1, 8'hA0, 0); push(1, 8'h9C, 0); push(1, 8'h01, 0); push(3, 0, 0);
    launch(2'd0, SDEV, 32'h0000009C, 3'd1, 8'd3);
    finish("R8 inj", c, e);
    inj_step = -1;
    check("R8 inj err", e, 32'h01483028);
    check_log("R8/R10 abort");
  endtask

  task automatic t_inj_read;
    int c; logic [31:0] e;
    inj_step = 3; inj_code = 8'h58;
    exp_n = 0;
    push(0, 0, 0); push(1, 8'hA1, 0); push(2, 0, 1); push(2, 0, 1); push(3, 0, 0);
    launch(2'd1, SDEV, 32'h0, 3'd0, 8'd3);
    finish("R6 inj", c, e);
    inj_step = -1;
    check("R6/R12 inj err", e, 32'h014C5850);
    check_log("R6 abort");
    check("R6 withheld", rd_n, 1);
    check("R6 kept byte", {24'd0, rd_buf[0]}, 32'hC0);
  endtask

  task automatic t_hang_start;
    int c; logic [31:0] e;
    hang_step = 0;
    exp_n = 0;
    push(0, 0, 0); push(3, 0, 0);
    launch(2'd0, SDEV, 32'h0, 3'd0, 8'd1);
    finish("R9 hang", c, e);
    hang_step = -1;
    check("R9 hang err", e, 32'h0260F808);
    check("R9 not early", {31'd0, c >= LIMIT}, 32'd1);
    check("R9 not late", {31'd0, c <= LIMIT + 40}, 32'd1);
    check_log("R9/R10 hang");
  endtask

  task automatic t_busy;
    int c, d0; logic [31:0] e;
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
    exp_n = 0;
    push(0, 0, 0); push(1, 8'hA0, 0); push(1, 8'hE1, 0); push(1, 8'hE2, 0); push(3, 0, 0);
    d0 = done_total;
    launch(2'd0, SDEV, 32'h0, 3'd0, 8'd2);
    repeat (3) @(negedge clk);
    cmd_kind = 2'd2; cmd_dev = 7'h22; cmd_valid = 1'b1;
    repeat (4) @(negedge clk);
    cmd_valid = 1'b0;
    finish("R1 busy", c, e);
    check("R1 busy err", e, 32'h0);
    check_log("R1 ignored");
    check("R1 single done", done_total - d0, 1);
  endtask

  task automatic t_stop_hang;
    int c; logic [31:0] e;
    stop_hang = 1'b1;
    wbuf[0] = 8'h66;
    launch(2'd0, SDEV, 32'h0, 3'd0, 8'd1);
    finish("R10 stop", c, e);
    check("R10 stop timeout err", e, 32'h025028F8);
    check("R10 stop wait", {31'd0, c >= LIMIT}, 32'd1);
  endtask

  task automatic t_priority;
    int c; logic [31:0] e;
    stop_hang = 1'b1; inj_step = 1; inj_code = 8'h20;
    exp_n = 0;
    push(0, 0, 0); push(1, 8'hA0, 0); push(3, 0, 0);
    launch(2'd0, SDEV, 32'h0, 3'd0, 8'd1);
    finish("R10 prio", c, e);
    inj_step = -1; stop_hang = 1'b0;
    check("R10 first failure kept", e, 32'h01482018);
    check_log("R10 prio");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset ready", {31'd0, cmd_ready}, 32'd1);
    check("R11 reset done", {31'd0, done}, 32'd0);
    check("R11 reset err", err, 32'h0);
    check("R1 reset req", {31'd0, eng_req}, 32'd0);
    t_write_off2();
    t_write_clamp();
    t_write_empty();
    t_read_off();
    t_read_plain();
    t_probe_ok();
    t_probe_miss();
    t_inj_write();
    t_inj_read();
    t_hang_start();
    t_busy();
    t_stop_hang();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc_total <= cyc_total + 1;
    if (cyc_total > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc_total);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule